// File: doc/BRIEF.md
# Flash Write-Gating and Sector-Swap Controller

This block sits between a CPU register bus and an on-chip flash array. It holds a control/status register and an 8-bit per-sector write-enable register. It passes a program or erase command to the array only when the global write-enable bit and the enable bit of the target sector are both set. Each accepted command produces a single-cycle strobe towards the array. The block then waits in a busy state until the array reports completion. On completion it latches a done flag, and it can raise an interrupt from that flag.

The block also remaps addresses. When the swap bit is set, a low 2 KB window (0x1800–0x1FFF) and the top-of-memory 2 KB window (0xF800–0xFFFF) exchange places. This mapping is applied both to a free-standing CPU fetch/read address and to the address of every command. Sector gating always uses the physical address after remapping. A command that fails gating is dropped and recorded in an access-error flag. A command that arrives while an operation is in flight is ignored.

Top module: `flash_wgate_ctrl`

## Requirements
- R1: After reset both registers read 0x00: writes disabled, interrupt disabled, no swap, no sector enabled, no flags. `irq` and `flash_strobe` are 0.
- R2: With the write-enable bit (status bit 1) at 0, a command raises no `flash_strobe`, even if its sector is enabled.
- R3: With write enable at 1, a command whose sector bit in the sector register (register select 1, bit n = sector n) is 0 raises no `flash_strobe`.
- R4: An accepted command drives `flash_strobe` high for exactly the one cycle after it is presented. During that cycle `flash_addr` carries the physical address, `flash_erase` carries the operation (0 program, 1 erase) and `flash_wdata` carries the data. The busy bit (status bit 5) reads 1 until `flash_done`.
- R5: `flash_done` while busy clears busy and sets the done flag (status bit 3). The flag stays set until a status write with bit 3 = 1 clears it.
- R6: `irq` is high exactly while the done flag and the interrupt-enable bit (status bit 2) are both 1.
- R7: A command presented while busy produces no strobe and does not set the error flag.
- R8: With the swap bit (status bit 0) at 0, `phys_addr` equals `cpu_addr`. With it at 1, addresses in 0x1800–0x1FFF map to 0xF800–0xFFFF and the reverse, keeping the low 11 bits. All other addresses are unchanged.
- R9: The sector used for gating is physical address bits [15:13], taken after the swap remap.
- R10: A rejected command sets the error flag (status bit 4) and leaves busy and done at 0. The error flag is cleared by a status write with bit 4 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status/control, 1 sector enables |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| cpu_addr | input | 16 | CPU access address to remap |
| phys_addr | output | 16 | Remapped physical address |
| cmd_valid | input | 1 | Program/erase command presented |
| cmd_erase | input | 1 | Command type: 0 program, 1 erase |
| cmd_addr | input | 16 | CPU address of the command |
| cmd_wdata | input | 8 | Program data |
| flash_strobe | output | 1 | One-cycle operation start to the array |
| flash_erase | output | 1 | Operation type to the array |
| flash_addr | output | 16 | Physical address to the array |
| flash_wdata | output | 8 | Data to the array |
| flash_done | input | 1 | Array reports operation complete |
| irq | output | 1 | Completion interrupt request |

## Verification
The hardest case to reach is a command whose sector decision changes under the swap bit. The same CPU address must be rejected with swap off and accepted with swap on, where only the sector holding the top window is enabled. The stimulus reaches it by enabling sector 7 alone, issuing the same erase at 0x1900 under both swap settings, and checking both the rejection and the remapped array address. A second case is a command sent during the busy window. The stub completion is delayed so that a second command lands mid-operation, and the bench confirms that it produces neither a strobe nor an error flag.

// File: rtl/flash_wgate_pkg.sv
package flash_wgate_pkg;
    localparam int ST_SWAP = 0;
    localparam int ST_WEN  = 1;
    localparam int ST_IEN  = 2;
    localparam int ST_DONE = 3;
    localparam int ST_ERR  = 4;
    localparam int ST_BUSY = 5;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_SECTOR = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/flash_addr_remap.sv
module flash_addr_remap #(
    parameter int ADDR_W  = 16,
    parameter int WIN_W   = 11,
    parameter logic [ADDR_W-1:0] LO_BASE = 16'h1800,
    parameter logic [ADDR_W-1:0] HI_BASE = 16'hF800
) (
    input  logic              swap,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int TAG_W = ADDR_W - WIN_W;

    logic [TAG_W-1:0] tag;
    logic             in_lo;
    logic             in_hi;

    always_comb begin
        tag   = addr_in[ADDR_W-1:WIN_W];
        in_lo = (tag == LO_BASE[ADDR_W-1:WIN_W]);
        in_hi = (tag == HI_BASE[ADDR_W-1:WIN_W]);
        addr_out = addr_in;
        if (swap && in_lo) begin
            addr_out = {HI_BASE[ADDR_W-1:WIN_W], addr_in[WIN_W-1:0]};
        end else if (swap && in_hi) begin
            addr_out = {LO_BASE[ADDR_W-1:WIN_W], addr_in[WIN_W-1:0]};
        end
    end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate #(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 3
) (
    input  logic                  cmd_valid,
    input  logic                  busy,
    input  logic                  wen,
    input  logic [ADDR_W-1:0]     phys_addr,
    input  logic [(1<<SECT_W)-1:0] sect_en,
    output logic                  gate_hit,
    output logic                  accept,
    output logic                  reject
);
    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W-1:0] sect_idx;
    logic [NSECT-1:0]  sect_sel;

    assign sect_idx = phys_addr[ADDR_W-1 -: SECT_W];

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign sect_sel[g] = (sect_idx == SECT_W'(g));
    end

    always_comb begin
        gate_hit = wen && (|(sect_sel & sect_en));
        accept   = cmd_valid && !busy && gate_hit;
        reject   = cmd_valid && !busy && !gate_hit;
    end
endmodule

// File: rtl/flash_wgate_regs.sv
module flash_wgate_regs
    import flash_wgate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              accept,
    input  logic              reject,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_phys,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              flash_done,
    output logic              swap,
    output logic              wen,
    output logic              ien,
    output logic              done,
    output logic              busy,
    output logic [NSECT-1:0]  sect_en,
    output logic              flash_strobe,
    output logic              flash_erase,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_wdata
);
    typedef struct packed {
        logic              swap;
        logic              wen;
        logic              ien;
        logic              done;
        logic              err;
        logic              busy;
        logic [NSECT-1:0]  sect_en;
        logic              strobe;
        logic              erase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (reg_wr_en) begin
            if (reg_sel == SEL_STATUS) begin
                s_d.swap = reg_wdata[ST_SWAP];
                s_d.wen  = reg_wdata[ST_WEN];
                s_d.ien  = reg_wdata[ST_IEN];
                if (reg_wdata[ST_DONE]) s_d.done = 1'b0;
                if (reg_wdata[ST_ERR])  s_d.err  = 1'b0;
            end else begin
                s_d.sect_en = reg_wdata[NSECT-1:0];
            end
        end
        if (s_q.busy && flash_done) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end
        if (accept) begin
            s_d.busy   = 1'b1;
            s_d.strobe = 1'b1;
            s_d.erase  = cmd_erase;
            s_d.addr   = cmd_phys;
            s_d.wdata  = cmd_wdata;
        end
        if (reject) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_STATUS) begin
            reg_rdata[ST_SWAP] = s_q.swap;
            reg_rdata[ST_WEN]  = s_q.wen;
            reg_rdata[ST_IEN]  = s_q.ien;
            reg_rdata[ST_DONE] = s_q.done;
            reg_rdata[ST_ERR]  = s_q.err;
            reg_rdata[ST_BUSY] = s_q.busy;
        end else begin
            reg_rdata[NSECT-1:0] = s_q.sect_en;
        end
    end

    assign swap         = s_q.swap;
    assign wen          = s_q.wen;
    assign ien          = s_q.ien;
    assign done         = s_q.done;
    assign busy         = s_q.busy;
    assign sect_en      = s_q.sect_en;
    assign flash_strobe = s_q.strobe;
    assign flash_erase  = s_q.erase;
    assign flash_addr   = s_q.addr;
    assign flash_wdata  = s_q.wdata;
endmodule

// File: rtl/flash_wgate_ctrl.sv
module flash_wgate_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3,
    parameter int WIN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] phys_addr,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              flash_strobe,
    output logic              flash_erase,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_wdata,
    input  logic              flash_done,
    output logic              irq
);
    localparam int NSECT = 1 << SECT_W;

    logic              swap, wen, ien, done, busy;
    logic [NSECT-1:0]  sect_en;
    logic [ADDR_W-1:0] cmd_phys;
    logic              gate_hit, accept, reject;

    flash_addr_remap #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_remap_cpu (
        .swap     (swap),
        .addr_in  (cpu_addr),
        .addr_out (phys_addr)
    );

    flash_addr_remap #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_remap_cmd (
        .swap     (swap),
        .addr_in  (cmd_addr),
        .addr_out (cmd_phys)
    );

    flash_cmd_gate #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_gate (
        .cmd_valid (cmd_valid),
        .busy      (busy),
        .wen       (wen),
        .phys_addr (cmd_phys),
        .sect_en   (sect_en),
        .gate_hit  (gate_hit),
        .accept    (accept),
        .reject    (reject)
    );

    flash_wgate_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .accept       (accept),
        .reject       (reject),
        .cmd_erase    (cmd_erase),
        .cmd_phys     (cmd_phys),
        .cmd_wdata    (cmd_wdata),
        .flash_done   (flash_done),
        .swap         (swap),
        .wen          (wen),
        .ien          (ien),
        .done         (done),
        .busy         (busy),
        .sect_en      (sect_en),
        .flash_strobe (flash_strobe),
        .flash_erase  (flash_erase),
        .flash_addr   (flash_addr),
        .flash_wdata  (flash_wdata)
    );

    assign irq = done && ien;
endmodule

// File: rtl/flash_wgate_chk.sv
module flash_wgate_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic wen,
    input logic gate_hit,
    input logic done,
    input logic flash_strobe,
    input logic flash_done
);
    // R2: a strobe only follows a cycle with global write enable set
    a_r2_strobe_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        flash_strobe |-> $past(wen));

    // R3: a strobe only follows a cycle where the sector gate passed
    a_r3_strobe_needs_sector: assert property (@(posedge clk) disable iff (!rst_n)
        flash_strobe |-> $past(gate_hit));

    // R4: strobe lasts a single cycle and coincides with busy
    a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flash_strobe |=> !flash_strobe);
    a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        flash_strobe |-> busy);

    // R5: done flag only rises from a completion during busy
    a_r5_done_from_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy && flash_done));

    // R7: commands during busy start nothing
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !flash_strobe);
endmodule

bind flash_wgate_ctrl flash_wgate_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .wen          (wen),
    .gate_hit     (gate_hit),
    .done         (done),
    .flash_strobe (flash_strobe),
    .flash_done   (flash_done)
);

// File: tb/test_flash_wgate_ctrl.sv
module test_flash_wgate_ctrl;
    localparam int BUSY_CYC = 6;
    localparam int MAX_CYC  = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic [15:0] phys_addr;
    logic        cmd_valid = 1'b0;
    logic        cmd_erase = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        flash_strobe, flash_erase;
    logic [15:0] flash_addr;
    logic [7:0]  flash_wdata;
    logic        flash_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    flash_wgate_ctrl i_flash_wgate_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .flash_strobe(flash_strobe), .flash_erase(flash_erase), .flash_addr(flash_addr),
        .flash_wdata(flash_wdata), .flash_done(flash_done), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > MAX_CYC) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, MAX_CYC);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    // presents a command for one cycle; returns at the negedge after capture
    task automatic issue(input logic erase, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = erase; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic complete();
        repeat (BUSY_CYC) @(negedge clk);
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R1 status", v, 8'h00);
        rd(1'b1, v); check("R1 sectors", v, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 strobe", flash_strobe, 0);
    endtask

    task automatic t_global_gate();
        logic [7:0] v;
        wr(1'b1, 8'hFF);
        issue(1'b0, 16'h2000, 8'h5A);
        check("R2 no strobe wen=0", flash_strobe, 0);
        rd(1'b0, v);
        check("R10 err set, no busy/done", v, 8'h10);
        wr(1'b0, 8'h10);
        rd(1'b0, v);
        check("R10 err cleared", v, 8'h00);
    endtask

    task automatic t_sector_and_op();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h02);
        issue(1'b0, 16'h2000, 8'h5A);
        check("R3 no strobe sector off", flash_strobe, 0);
        rd(1'b0, v);
        check("R3 err set", v, 8'h12);
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h02);
        issue(1'b0, 16'h2034, 8'hC3);
        check("R4 strobe", flash_strobe, 1);
        check("R4 addr", flash_addr, 16'h2034);
        check("R4 data", flash_wdata, 8'hC3);
        check("R4 op program", flash_erase, 0);
        rd(1'b0, v);
        check("R4 busy reads 1", v, 8'h22);
        @(negedge clk);
        check("R4 strobe one cycle", flash_strobe, 0);
        issue(1'b1, 16'h2100, 8'h11);
        check("R7 no strobe while busy", flash_strobe, 0);
        rd(1'b0, v);
        check("R7 no err while busy", v, 8'h22);
        complete();
        rd(1'b0, v);
        check("R5 done set busy clear", v, 8'h0A);
        check("R6 irq off ien=0", irq, 0);
        wr(1'b0, 8'h06);
        check("R6 irq on", irq, 1);
        rd(1'b0, v);
        check("R5 done holds", v, 8'h0E);
        wr(1'b0, 8'h0E);
        rd(1'b0, v);
        check("R5 done cleared", v, 8'h06);
        check("R6 irq off after clear", irq, 0);
    endtask

    task automatic t_swap();
        logic [7:0] v;
        wr(1'b0, 8'h02);
        cpu_addr = 16'h1810; #1 check("R8 no swap low", phys_addr, 16'h1810);
        cpu_addr = 16'hF8AB; #1 check("R8 no swap high", phys_addr, 16'hF8AB);
        wr(1'b0, 8'h03);
        cpu_addr = 16'h1810; #1 check("R8 swap low->high", phys_addr, 16'hF810);
        cpu_addr = 16'hF8AB; #1 check("R8 swap high->low", phys_addr, 16'h18AB);
        cpu_addr = 16'h4000; #1 check("R8 outside window", phys_addr, 16'h4000);
        cpu_addr = 16'hF7FF; #1 check("R8 below top window", phys_addr, 16'hF7FF);
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h02);
        issue(1'b1, 16'h1900, 8'h00);
        check("R9 sector0 rejected unswapped", flash_strobe, 0);
        rd(1'b0, v);
        check("R9 err set unswapped", v, 8'h12);
        wr(1'b0, 8'h13);
        issue(1'b1, 16'h1900, 8'h00);
        check("R9 accepted after swap", flash_strobe, 1);
        check("R9 remapped addr", flash_addr, 16'hF900);
        check("R9 erase op", flash_erase, 1);
        complete();
        rd(1'b0, v);
        check("R5 done after erase", v, 8'h0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_gate();
        t_sector_and_op();
        t_swap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule